// File: doc/BRIEF.md
# Precision Time Protocol Clock Core

This block keeps a free-running 64-bit nanosecond time counter for IEEE 1588 style time synchronization. Each enabled clock cycle is one reference tick. On every tick the counter advances by a 32.32 fixed-point period. A 32-bit fractional accumulator adds the fractional addend, and the counter moves by the integer period plus the carry out of that addition. The reported current time is the raw counter plus a signed 64-bit offset. Software applies step corrections by changing the offset, which leaves the counter running and loses no ticks.

Software reaches the block through a simple 32-bit register bus. One write or one read happens per cycle, and read data returns one cycle after the read strobe. Each 64-bit quantity is split into two 32-bit halves. The counter and the offset each take a low-half write into a shadow register, and the high-half write commits both halves at once. A read of the low half of current time freezes the matching high half, so the later high-half read returns a value from the same sample. An atomic-update mode holds back a new integer period until the fractional addend is next written, so both parts of the period change together.

Top module: `ptp_clock_core`

## Requirements
- R1: After reset, the counter, offset, addend, accumulator, committed integer period and every control field are zero, every register reads zero, and current time does not advance.
- R2: On each cycle with the enable bit set, the fractional accumulator adds the addend modulo 2^32. The counter adds the committed integer period plus one when that addition carries out, which is exact 32.32 fixed-point accumulation.
- R3: The control register is at word address 0. Clock select is in bits 1:0, enable in bit 2, atomic-update mode in bit 15 and the 10-bit integer period field in bits 25:16. A read returns these fields with all other bits zero. Control writes are accepted whether or not the block is enabled.
- R4: When a control write sets bit 15, the new integer period field is not used for counting until the next accepted write to the addend register (address 1). From the tick after that write onward, the new integer and fractional parts apply together.
- R5: When a control write clears bit 15, the integer period field in that write is used from the next tick onward.
- R6: A write to counter-low (address 2) only fills a shadow register and does not change time. A write to counter-high (address 3) loads the counter with {written value, shadow} on that edge, and this load replaces the tick for that cycle.
- R7: Current time equals the counter plus the offset, modulo 2^64, with the offset read as signed two's complement. The offset takes a low write (address 4) into a shadow and commits {high, shadow} on a high write (address 5). Addresses 4 and 5 read back the committed offset halves.
- R8: A read of current-time low (address 6) returns bits 31:0 of current time and, on the same edge, latches bits 63:32. A read of current-time high (address 7) returns that latched value, however far time has moved since.
- R9: While the enable bit is clear, the counter and accumulator hold, and writes to addresses 1 to 5 are ignored.
- R10: Read data is registered and appears on the cycle after the read strobe. Address 1 reads the addend, and addresses 2 and 3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each enabled cycle is one tick |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 3 | Word address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |

## Verification
The bench uses the package defaults: a 10-bit integer period field and a 32-bit fraction. With these widths, any integer step up to 1023 ns, and addends near one half, give frequent fractional carries within a few dozen ticks. The counter is preloaded just below a low-half wrap. This lets the bench see a frozen high half differ from the live time after only a few ticks, and show a negative offset borrowing across the 32-bit boundary. The reference model adds a 96-bit fixed-point value behaviourally and predicts every read the bench issues.

// File: rtl/ptp_clock_pkg.sv
package ptp_clock_pkg;
  localparam int TIME_W = 64;
  localparam int HALF_W = TIME_W / 2;
  localparam int FRAC_W = 32;
  localparam int INT_W = 10;
  localparam int ADDR_W = 3;

  localparam int SEL_LSB = 0;
  localparam int SEL_W = 2;
  localparam int EN_BIT = 2;
  localparam int ATOM_BIT = 15;
  localparam int INT_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_ADDEND = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_OFF_LO = 3'd4,
    A_OFF_HI = 3'd5,
    A_NOW_LO = 3'd6,
    A_NOW_HI = 3'd7
  } regAddr_t;

  typedef struct packed {
    logic setInt;
    logic [INT_W-1:0] intVal;
    logic loadAddend;
    logic [FRAC_W-1:0] addendVal;
    logic loadCnt;
    logic [TIME_W-1:0] cntVal;
    logic loadOff;
    logic [TIME_W-1:0] offVal;
  } strobe_t;
endpackage

// File: rtl/ptp_clock_datapath.sv
module ptp_clock_datapath
  import ptp_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  strobe_t           strb,
  output logic [TIME_W-1:0] rawCnt,
  output logic [TIME_W-1:0] offVal,
  output logic [FRAC_W-1:0] addendVal,
  output logic [TIME_W-1:0] nowTime
);
  logic [INT_W-1:0]  commitInt;
  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   fracSum;
  logic [TIME_W-1:0] step;

  // Carry out of the fractional accumulator adds one extra nanosecond.
  assign fracSum = {1'b0, fracAcc} + {1'b0, addendVal};
  assign step = TIME_W'(commitInt) + TIME_W'(fracSum[FRAC_W]);
  assign nowTime = rawCnt + offVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitInt <= '0;
      addendVal <= '0;
      fracAcc   <= '0;
      rawCnt    <= '0;
      offVal    <= '0;
    end else begin
      if (strb.setInt) commitInt <= strb.intVal;
      if (strb.loadAddend) addendVal <= strb.addendVal;
      if (tickEn) fracAcc <= fracSum[FRAC_W-1:0];
      if (strb.loadCnt) rawCnt <= strb.cntVal;
      else if (tickEn) rawCnt <= rawCnt + step;
      if (strb.loadOff) offVal <= strb.offVal;
    end
  end
endmodule

// File: rtl/ptp_clock_ctrl.sv
module ptp_clock_ctrl
  import ptp_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [HALF_W-1:0] busWrData,
  input  logic [TIME_W-1:0] nowTime,
  input  logic [TIME_W-1:0] offVal,
  input  logic [FRAC_W-1:0] addendVal,
  output strobe_t           strb,
  output logic              ctrlEn,
  output logic [HALF_W-1:0] busRdData
);
  logic [SEL_W-1:0]  clkSel;
  logic              atomic;
  logic [INT_W-1:0]  intField;
  logic [HALF_W-1:0] cntLoSh;
  logic [HALF_W-1:0] offLoSh;
  logic [HALF_W-1:0] nowHiLatch;
  logic [HALF_W-1:0] rdMux;
  logic              wrCtrl;
  logic              timerWr;

  assign wrCtrl = busWrEn && (busAddr == A_CTRL);
  // Timer-domain registers accept writes only while enabled.
  assign timerWr = busWrEn && ctrlEn;

  always_comb begin
    strb = '0;
    strb.setInt = (wrCtrl && !busWrData[ATOM_BIT]) ||
                  (timerWr && (busAddr == A_ADDEND));
    strb.intVal = wrCtrl ? busWrData[INT_LSB +: INT_W] : intField;
    strb.loadAddend = timerWr && (busAddr == A_ADDEND);
    strb.addendVal = FRAC_W'(busWrData);
    strb.loadCnt = timerWr && (busAddr == A_CNT_HI);
    strb.cntVal = {busWrData, cntLoSh};
    strb.loadOff = timerWr && (busAddr == A_OFF_HI);
    strb.offVal = {busWrData, offLoSh};
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      A_CTRL: begin
        rdMux[SEL_LSB +: SEL_W] = clkSel;
        rdMux[EN_BIT] = ctrlEn;
        rdMux[ATOM_BIT] = atomic;
        rdMux[INT_LSB +: INT_W] = intField;
      end
      A_ADDEND: rdMux = HALF_W'(addendVal);
      A_OFF_LO: rdMux = offVal[HALF_W-1:0];
      A_OFF_HI: rdMux = offVal[TIME_W-1:HALF_W];
      A_NOW_LO: rdMux = nowTime[HALF_W-1:0];
      A_NOW_HI: rdMux = nowHiLatch;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel     <= '0;
      ctrlEn     <= 1'b0;
      atomic     <= 1'b0;
      intField   <= '0;
      cntLoSh    <= '0;
      offLoSh    <= '0;
      nowHiLatch <= '0;
      busRdData  <= '0;
    end else begin
      if (wrCtrl) begin
        clkSel   <= busWrData[SEL_LSB +: SEL_W];
        ctrlEn   <= busWrData[EN_BIT];
        atomic   <= busWrData[ATOM_BIT];
        intField <= busWrData[INT_LSB +: INT_W];
      end
      if (timerWr && (busAddr == A_CNT_LO)) cntLoSh <= busWrData;
      if (timerWr && (busAddr == A_OFF_LO)) offLoSh <= busWrData;
      if (busRdEn) begin
        busRdData <= rdMux;
        if (busAddr == A_NOW_LO) nowHiLatch <= nowTime[TIME_W-1:HALF_W];
      end
    end
  end
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
  import ptp_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [HALF_W-1:0] busWrData,
  output logic [HALF_W-1:0] busRdData
);
  strobe_t           strb;
  logic              ctrlEn;
  logic [TIME_W-1:0] rawCnt;
  logic [TIME_W-1:0] offVal;
  logic [FRAC_W-1:0] addendVal;
  logic [TIME_W-1:0] nowTime;

  ptp_clock_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .nowTime(nowTime),
    .offVal(offVal), .addendVal(addendVal), .strb(strb),
    .ctrlEn(ctrlEn), .busRdData(busRdData)
  );

  ptp_clock_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(ctrlEn), .strb(strb),
    .rawCnt(rawCnt), .offVal(offVal), .addendVal(addendVal),
    .nowTime(nowTime)
  );
endmodule

// File: rtl/ptp_clock_core_chk.sv
module ptp_clock_core_chk
  import ptp_clock_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [HALF_W-1:0] busWrData,
  input logic [HALF_W-1:0] busRdData,
  input logic              ctrlEn,
  input logic [TIME_W-1:0] rawCnt,
  input logic [TIME_W-1:0] offVal
);
  logic cntLoad;
  assign cntLoad = busWrEn && ctrlEn && (busAddr == A_CNT_HI);

  // R9: a disabled counter holds.
  p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> $stable(rawCnt));

  // R2: an enabled tick never moves time backwards.
  p_monotonic_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && !cntLoad) |=> rawCnt >= $past(rawCnt));

  // R2: one tick advances by at most the largest integer period plus one carry.
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && !cntLoad) |=> (rawCnt - $past(rawCnt)) <= TIME_W'(1 << INT_W));

  // R6: a high-half write loads the upper counter bits.
  p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |=> rawCnt[TIME_W-1:HALF_W] == $past(busWrData));

  // R7: a low-half offset write alone leaves the offset unchanged.
  p_off_shadow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_OFF_LO) |=> $stable(offVal));

  // R10: counter addresses read as zero.
  p_cnt_rd_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr == A_CNT_LO || busAddr == A_CNT_HI)) |=> busRdData == '0);
endmodule

bind ptp_clock_core ptp_clock_core_chk chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .ctrlEn(ctrlEn), .rawCnt(rawCnt), .offVal(offVal)
);

// File: tb/ptp_clock_core_tb_top.sv
`timescale 1ns/1ps
module ptp_clock_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;

  int checks = 0;
  int bad = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ptp_clock_core dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  // Behavioural reference model
  logic [63:0] mCnt, mOff, mLatch;
  logic [31:0] mFrac, mAdd, mCntSh, mOffSh, expData;
  logic [9:0]  mField, mInt;
  logic        mEn, mAtom, expPend;
  logic [1:0]  mSel;
  string       expReq;
  logic [95:0] acc;
  logic [63:0] nowV;
  logic        oldEn;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mOff = 0; mLatch = 0; mFrac = 0; mAdd = 0;
      mCntSh = 0; mOffSh = 0; mField = 0; mInt = 0;
      mEn = 0; mAtom = 0; mSel = 0; expPend = 0;
    end else begin
      nowV = mCnt + mOff;
      expPend = busRdEn;
      expReq = curReq;
      case (busAddr)
        3'd0: expData = {6'b0, mField, mAtom, 12'b0, mEn, mSel};
        3'd1: expData = mAdd;
        3'd4: expData = mOff[31:0];
        3'd5: expData = mOff[63:32];
        3'd6: expData = nowV[31:0];
        3'd7: expData = mLatch;
        default: expData = 32'd0;
      endcase
      if (busRdEn && busAddr == 3'd6) mLatch = nowV[63:32];
      oldEn = mEn;
      if (mEn) begin
        acc = {mCnt, mFrac} + {54'd0, mInt, 32'd0} + {64'd0, mAdd};
        mCnt = acc[95:32];
        mFrac = acc[31:0];
      end
      if (busWrEn) begin
        if (busAddr == 3'd0) begin
          mSel = busWrData[1:0]; mEn = busWrData[2];
          mAtom = busWrData[15]; mField = busWrData[25:16];
          if (!busWrData[15]) mInt = busWrData[25:16];
        end else if (oldEn) begin
          case (busAddr)
            3'd1: begin mAdd = busWrData; mInt = mField; end
            3'd2: mCntSh = busWrData;
            3'd3: mCnt = {busWrData, mCntSh};
            3'd4: mOffSh = busWrData;
            3'd5: mOff = {busWrData, mOffSh};
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (expPend && !finished) begin
      checks++;
      if (busRdData !== expData) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", expReq, busAddr, busRdData, expData);
      end
      expPend = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); busRdEn = 1'b1; busAddr = a;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readNow();
    rd(3'd6); rd(3'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (busRdData !== 32'd0) begin
      bad++; $display("FAIL R1 rdData after reset actual=%h expected=0", busRdData);
    end
    curReq = "R1";
    for (int a = 0; a < 8; a++) rd(a[2:0]);
    idle(5); readNow();

    curReq = "R9";
    wr(3'd1, 32'h8000_0000); wr(3'd2, 32'h11); wr(3'd3, 32'h22);
    wr(3'd4, 32'h33); wr(3'd5, 32'h44);
    rd(3'd1); rd(3'd4); rd(3'd5); readNow();

    curReq = "R3";
    wr(3'd0, (32'd4 << 16) | 32'h4 | 32'h3);
    rd(3'd0);
    curReq = "R2";
    wr(3'd1, 32'h8000_0000);
    rd(3'd1);
    idle(20); readNow();
    wr(3'd1, 32'h5555_5555);
    idle(33); readNow();

    curReq = "R4";
    wr(3'd0, (32'd7 << 16) | 32'h8004);
    rd(3'd0);
    idle(10); readNow();
    wr(3'd1, 32'h4000_0000);
    idle(10); readNow();

    curReq = "R5";
    wr(3'd0, (32'd3 << 16) | 32'h4);
    idle(10); readNow();

    curReq = "R6";
    wr(3'd2, 32'hFFFF_FFC0);
    idle(4); readNow();
    rd(3'd2); rd(3'd3);
    wr(3'd3, 32'h0000_0005);
    readNow();

    curReq = "R8";
    rd(3'd6); idle(40); rd(3'd7);
    readNow();

    curReq = "R7";
    wr(3'd4, 32'hFFFF_FF00);
    rd(3'd4); readNow();
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd4); rd(3'd5); readNow();
    wr(3'd2, 32'h0000_0080); wr(3'd3, 32'h0000_0000);
    readNow();
    wr(3'd4, 32'h0000_1000); wr(3'd5, 32'h0);
    readNow();

    curReq = "R9";
    wr(3'd0, (32'd3 << 16));
    readNow(); idle(8); readNow();
    wr(3'd1, 32'h1234_5678); wr(3'd4, 32'h1); wr(3'd5, 32'h1);
    rd(3'd1); rd(3'd4); rd(3'd5); readNow();

    curReq = "R10";
    wr(3'd0, (32'd1000 << 16) | 32'h4);
    wr(3'd1, 32'hF0F0_F0F1);
    for (int i = 0; i < 600; i++) begin
      readNow();
      if (i % 97 == 0) wr(3'd1, 32'h9E37_79B9 * (i + 1));
      if (i % 151 == 0) wr(3'd0, ((32'(i) % 1024) << 16) | 32'h4);
    end
    rd(3'd2); rd(3'd3);

    idle(3);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule